// File: doc/BRIEF.md
# Free-Running Idle Timer with Toggle Interrupt

This block is a background time base that counts down by one on every instruction-cycle tick and never stops. Software has no way to load or observe the count. The block watches one tap bit of the counter. Whenever that bit changes value, the event is latched into a sticky pending flag. A software-controlled enable decides whether the pending flag raises the interrupt line.

The tap is the highest bit of a counter that is one bit wider than the period exponent. With the default exponent of 12, the tap changes once every 4096 ticks, and it does so in both directions. Software clears the pending flag with a one-cycle clear strobe. It writes the enable through a write strobe and a data bit, and it can read the enable and the flag back on the outputs.

Top module: `idle_tmr`

## Requirements
- R1: After reset the pending flag, the enable and the interrupt are all 0, and the counter holds all ones. As a result, the first event comes after exactly 4096 ticks.
- R2: The counter moves only on clock edges where `tick_i` is 1. Clock cycles without a tick do not bring an event any closer.
- R3: Each time the number of ticks since reset reaches a multiple of 4096, `pend_o` reads 1 two clock edges after the edge that took that tick in. Edge one updates the counter, and edge two latches the tap change. No other tick count sets `pend_o`.
- R4: The pending flag is set by an event even while the enable is 0.
- R5: `irq_o` is 1 exactly when both `pend_o` and `en_o` are 1.
- R6: When `en_we_i` is 1 at a clock edge, `en_o` takes the value of `en_wdata_i` after that edge. Otherwise `en_o` holds its value.
- R7: When `pend_clr_i` is 1 at an edge where no event is being latched, `pend_o` reads 0 after that edge.
- R8: When `pend_clr_i` is 1 at the same edge that latches an event, the event wins and `pend_o` stays 1.
- R9: Enable writes and pending clears do not change the counter, so the event timing depends only on the number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle count enable |
| en_we_i | input | 1 | Write strobe for the interrupt enable |
| en_wdata_i | input | 1 | Value written to the enable |
| pend_clr_i | input | 1 | One-cycle clear of the pending flag |
| en_o | output | 1 | Current interrupt enable |
| pend_o | output | 1 | Sticky event pending flag |
| irq_o | output | 1 | Interrupt request, pending gated by enable |

## Verification
The bench drives the block with three tick patterns. In the first, ticks arrive on every cycle. In the second, one tick arrives every third cycle. In the third, ticks arrive in irregular bursts. The event cycle must follow the tick count under all three patterns and never the raw cycle count. This separates correct count gating from a counter that runs on the clock. Enable writes and pending clears are mixed in around each event, and one clear is placed on the exact latching edge. This separates "set wins" from "clear wins", and it shows that clears and writes never shift the event timing.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;
    // Exponent of the event period in ticks.
    localparam int unsigned PERIOD_LOG2_DEF = 12;

    typedef struct packed {
        logic pend;
        logic en;
    } flag_state_t;
endpackage

// File: rtl/idle_tmr_counter.sv
module idle_tmr_counter #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2: the count stays put on cycles without a tick
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/idle_tmr_edge.sv
module idle_tmr_edge #(
    parameter logic RST_TAP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_i,
    output logic toggle_o
);
    typedef struct packed {
        logic tap;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tap = tap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tap <= RST_TAP;
        end else begin
            st_q <= st_d;
        end
    end

    assign toggle_o = tap_i ^ st_q.tap;
endmodule

// File: rtl/idle_tmr_flags.sv
module idle_tmr_flags
    import idle_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic clr_i,
    input  logic we_i,
    input  logic wdata_i,
    output logic pend_o,
    output logic en_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.en = wdata_i;
        end
        if (toggle_i) begin
            st_d.pend = 1'b1;
        end else if (clr_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

    // R3 R4 R8: a toggle always leaves the flag set, clear or not
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_i |=> pend_o);
    // R7: a clear without a competing toggle empties the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !toggle_i) |=> !pend_o);
    // R3: the flag changes only on a toggle or a clear
    a_r3_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i && !clr_i) |=> $stable(pend_o));
    // R6: the enable follows the written value
    a_r6_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
    import idle_tmr_pkg::*;
#(
    parameter int unsigned PERIOD_LOG2 = PERIOD_LOG2_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_we_i,
    input  logic en_wdata_i,
    input  logic pend_clr_i,
    output logic en_o,
    output logic pend_o,
    output logic irq_o
);
    localparam int unsigned CNT_W = PERIOD_LOG2 + 1;
    localparam int unsigned TAP   = PERIOD_LOG2;

    logic [CNT_W-1:0] cnt;
    logic             toggle;
    logic             pend;
    logic             en;

    idle_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    idle_tmr_edge #(.RST_TAP(1'b1)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_i    (cnt[TAP]),
        .toggle_o (toggle)
    );

    idle_tmr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (toggle),
        .clr_i    (pend_clr_i),
        .we_i     (en_we_i),
        .wdata_i  (en_wdata_i),
        .pend_o   (pend),
        .en_o     (en)
    );

    assign pend_o = pend;
    assign en_o   = en;
    assign irq_o  = pend & en;

    // R3: a tap change shows as a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !toggle);
    // R5: no interrupt without the enable
    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !irq_o);
    // R9: software strobes do not move the counter
    a_r9_sw_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && (en_we_i || pend_clr_i)) |=> $stable(cnt));
endmodule

// File: tb/idle_tmr_tb.sv
module idle_tmr_tb;
    localparam int PERIOD = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, we = 1'b0, wd = 1'b0, clr = 1'b0;
    logic en_o, pend_o, irq_o;

    int errors = 0, checks = 0, cycles = 0;
    int ticks = 0;
    bit evt_next = 1'b0;
    bit exp_pend = 1'b0, exp_en = 1'b0;

    always #10 clk = ~clk;

    idle_tmr u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_we_i(we),
        .en_wdata_i(wd), .pend_clr_i(clr),
        .en_o(en_o), .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b ticks=%0d", tag, act, exp, ticks);
        end
    endtask

    task automatic cmp_all(input string tag);
        check({tag, " pend"}, pend_o, exp_pend);
        check({tag, " en R6"}, en_o, exp_en);
        check({tag, " irq R5"}, irq_o, exp_pend & exp_en);
    endtask

    // One clock: drive at negedge, update model at posedge, compare at negedge.
    task automatic cyc(input bit t, input bit w, input bit d, input bit c, input string tag);
        tick = t; we = w; wd = d; clr = c;
        @(posedge clk);
        #1;
        if (evt_next) exp_pend = 1'b1;
        else if (c) exp_pend = 1'b0;
        if (w) exp_en = d;
        evt_next = 1'b0;
        if (t) begin
            ticks++;
            evt_next = ((ticks % PERIOD) == 0);
        end
        @(negedge clk);
        cmp_all(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1 after release");

        // R4 R3: back-to-back ticks, enable off, first event after 4096 ticks
        for (int i = 0; i < PERIOD + 4; i++) cyc(1, 0, 0, 0, "R3 R4 dense");
        check("R4 pend with enable off", pend_o, 1'b1);
        check("R5 irq blocked", irq_o, 1'b0);

        // R7 R6: clear, then enable
        cyc(0, 0, 0, 1, "R7 clear");
        check("R7 cleared", pend_o, 1'b0);
        cyc(0, 1, 1, 0, "R6 enable write");
        check("R6 enable on", en_o, 1'b1);

        // R2: one tick every third cycle across the next event
        for (int i = 0; i < 3 * (PERIOD + 4); i++)
            cyc(((i % 3) == 0), 0, 0, 0, "R2 sparse");
        check("R5 irq raised", irq_o, 1'b1);

        // R8: clear on the exact latching edge
        cyc(0, 0, 0, 1, "R7 clear again");
        while (((ticks + 1) % PERIOD) != 0) cyc(1, 0, 0, 0, "R3 approach");
        cyc(1, 0, 0, 0, "R3 flipping tick");
        check("R3 not yet latched", pend_o, 1'b0);
        cyc(0, 0, 0, 1, "R8 collision");
        check("R8 set wins", pend_o, 1'b1);

        // R9: irregular bursts with strobes; event timing by ticks only
        for (int i = 0; i < 2 * PERIOD + 600; i++)
            cyc(((i % 7) < 4), ((i % 53) == 5), ((i % 106) < 53), ((i % 97) == 11), "R9 mixed");

        // R5: disabling drops irq while pending stays
        cyc(0, 1, 1, 0, "R6 enable");
        cyc(0, 1, 0, 0, "R6 disable");
        check("R5 irq low when disabled", irq_o, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule